// File: doc/BRIEF.md
# Frequency-Synthesis Serial Register Port

This block is the control-register front end of a frequency-synthesis core. An external controller reaches it over three wires: an active-low chip select, a serial clock and a serial data input. A fourth wire carries serial data back out. Every transaction starts with one instruction byte. That byte says whether the access is a read or a write and which register it targets. The data bytes that follow go most significant bit first. How many there are depends only on the register addressed.

Written values go first into a holding bank. They reach the active bank, which the synthesis logic reads, only when a separate update strobe rises. A whole group of registers can therefore be changed in one step, and the update may come after chip select has been released. One chip-select low period may carry several register accesses in a row. A read shifts the active copy of the addressed register out on the serial output. All four pins are asynchronous to the system clock. They are synchronised inside the block, and the block acts on the rising edges of the serial clock and of the update strobe.

Top module: `dds_serial_regs`

## Requirements
- R1: After reset the active register at address 0 holds 0x0000000040 and every other active register holds zero. The serial output is 0.
- R2: The first byte after chip select falls is an instruction byte, taken MSB first with one bit per serial-clock rising edge. Bit 7 = 1 selects a read and 0 selects a write. Bits 4..0 give the address, and bits 6..5 have no effect.
- R3: The number of data bytes per address is fixed: address 0 takes 4, 1 takes 3, 2 takes 2, 3 takes 1, 4 takes 4, 5 takes 2, 6 takes 4, and each of 7 to 10 takes 5. Data bytes are taken MSB first, and the first bit received lands at the top of the register.
- R4: A completed write changes only the holding copy. The active bank stays unchanged until the update strobe rises. On that edge every holding register is copied into its active register.
- R5: Within one chip-select low period, the bit after a register's last data bit starts a new instruction byte. Any number of accesses may follow each other this way.
- R6: When chip select goes high, any partially received register is discarded and its holding copy is not changed. The next bit after chip select falls again is the first bit of an instruction byte.
- R7: An instruction addressing 0x0B to 0x1F causes every further bit to be ignored until chip select goes high.
- R8: For a read, the serial output carries the MSB of the addressed active register once the eighth instruction bit has been taken. Each further serial-clock rising edge advances it by one bit. The output is 0 outside the data phase of a read.
- R9: Each active register is right-aligned at its width of 8 times its byte count, and all bits above that width read as zero.
- R10: Holding registers reset to zero, so an update strobe with no write since reset clears the default value of address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data in |
| ioupd_i | input | 1 | Update strobe; its rising edge copies holding to active |
| sdo_o | output | 1 | Serial data out during a read |
| active_o | output | 11x40 | Active register bank, entry n is address n, right-aligned |

## Verification
The bench writes every register with several arithmetic patterns in a single chip-select period, and it also writes them in separate periods. A wrong byte count would shift the following instruction off its byte boundary and corrupt every later register in the burst. Before each update strobe the bench compares the active bank with the model, which catches a design that writes straight through. It also aborts a register part-way through a byte. A design that commits partial data, or that resumes mid-byte, would change that register or misread the next instruction. An unmapped instruction followed by a valid-looking write checks that skipping holds until chip select rises. Reads of freshly written but not yet updated registers, and of the reset default, confirm that readback comes from the active bank, MSB first.

// File: rtl/dds_regs_pkg.sv
package dds_regs_pkg;

    localparam int NREG = 11;
    localparam int MAXB = 5;
    localparam int MAXW = MAXB * 8;
    localparam int AW   = 5;
    localparam int BCW  = $clog2(MAXB + 1);

    typedef enum logic [1:0] {
        PH_INST = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef logic [NREG-1:0][MAXW-1:0] bank_t;

    function automatic logic [BCW-1:0] reg_bytes(input logic [AW-1:0] a);
        logic [BCW-1:0] n;
        case (a)
            5'd0, 5'd4, 5'd6:             n = BCW'(4);
            5'd1:                         n = BCW'(3);
            5'd2, 5'd5:                   n = BCW'(2);
            5'd3:                         n = BCW'(1);
            5'd7, 5'd8, 5'd9, 5'd10:      n = BCW'(5);
            default:                      n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dds_in_sync.sv
module dds_in_sync #(
    parameter int       W       = 4,
    parameter int       STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_q;
    logic [STAGES-1:0][W-1:0] chain_d;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dds_ser_fsm.sv
module dds_ser_fsm
    import dds_regs_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cs_off_i,
    input  logic            rise_i,
    input  logic            sdi_i,
    input  logic [MAXW-1:0] rd_word_i,
    output logic [AW-1:0]   rd_addr_o,
    output logic            wr_o,
    output logic [AW-1:0]   wr_addr_o,
    output logic [MAXW-1:0] wr_data_o,
    output logic            sdo_o
);

    typedef struct packed {
        phase_e          ph;
        logic [2:0]      bitc;
        logic [BCW-1:0]  left;
        logic [7:0]      inst;
        logic [MAXW-1:0] sh;
        logic [AW-1:0]   addr;
        logic            wr;
    } ser_t;

    ser_t q, d;
    logic [7:0]     inst_nx;
    logic [BCW-1:0] nb;
    logic [5:0]     lsh;

    assign inst_nx   = {q.inst[6:0], sdi_i};
    assign rd_addr_o = inst_nx[AW-1:0];

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        nb   = reg_bytes(inst_nx[AW-1:0]);
        lsh  = 6'((MAXB - int'(nb)) * 8);
        if (cs_off_i) begin
            d.ph   = PH_INST;
            d.bitc = '0;
            d.left = '0;
            d.inst = '0;
        end else if (rise_i) begin
            d.bitc = q.bitc + 3'd1;
            case (q.ph)
                PH_INST: begin
                    d.inst = inst_nx;
                    if (q.bitc == 3'd7) begin
                        d.addr = inst_nx[AW-1:0];
                        d.left = nb - BCW'(1);
                        if (nb == '0) begin
                            d.ph = PH_SKIP;
                        end else if (inst_nx[7]) begin
                            d.ph = PH_RD;
                            d.sh = rd_word_i << lsh;
                        end else begin
                            d.ph = PH_WR;
                            d.sh = '0;
                        end
                    end
                end
                PH_WR, PH_RD: begin
                    d.sh = {q.sh[MAXW-2:0], (q.ph == PH_WR) ? sdi_i : 1'b0};
                    if (q.bitc == 3'd7) begin
                        if (q.left == '0) begin
                            d.ph = PH_INST;
                            d.wr = (q.ph == PH_WR);
                        end else begin
                            d.left = q.left - BCW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{ph: PH_INST, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_o      = q.wr;
    assign wr_addr_o = q.addr;
    assign wr_data_o = q.sh;
    assign sdo_o     = (q.ph == PH_RD) & q.sh[MAXW-1];

endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
    import dds_regs_pkg::*;
#(
    parameter logic [MAXW-1:0] ADDR0_RST = 40'h00_0000_0040
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [MAXW-1:0] wr_data_i,
    input  logic            upd_i,
    output bank_t           active_o
);

    typedef struct packed {
        bank_t hold;
        bank_t act;
    } bank_st_t;

    bank_st_t q, d;

    always_comb begin
        d = q;
        if (upd_i) begin
            d.act = q.hold;
        end
        if (wr_i) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_addr_i == AW'(i)) begin
                    d.hold[i] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q        <= '0;
            q.act[0] <= ADDR0_RST;
        end else begin
            q <= d;
        end
    end

    assign active_o = q.act;

endmodule

// File: rtl/dds_serial_regs.sv
module dds_serial_regs
    import dds_regs_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [MAXW-1:0] ADDR0_RST   = 40'h00_0000_0040
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    csn_i,
    input  logic    sclk_i,
    input  logic    sdi_i,
    input  logic    ioupd_i,
    output logic    sdo_o,
    output bank_t   active_o
);

    typedef struct packed {
        logic sclk_prev;
        logic upd_prev;
    } edge_t;

    logic [3:0]      pins_s;
    logic            csn_s, sclk_s, sdi_s, upd_s;
    edge_t           eq, ed;
    logic            sclk_rise, upd_pulse;
    logic [AW-1:0]   rd_addr;
    logic [MAXW-1:0] rd_word;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [MAXW-1:0] wr_data;

    dds_in_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({ioupd_i, sdi_i, sclk_i, csn_i}),
        .sync_o  (pins_s)
    );

    assign csn_s  = pins_s[0];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[2];
    assign upd_s  = pins_s[3];

    always_comb begin
        ed.sclk_prev = sclk_s;
        ed.upd_prev  = upd_s;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eq <= '0;
        end else begin
            eq <= ed;
        end
    end

    assign sclk_rise = sclk_s & ~eq.sclk_prev;
    assign upd_pulse = upd_s & ~eq.upd_prev;

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_word = active_o[i];
            end
        end
    end

    dds_ser_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cs_off_i  (csn_s),
        .rise_i    (sclk_rise),
        .sdi_i     (sdi_s),
        .rd_word_i (rd_word),
        .rd_addr_o (rd_addr),
        .wr_o      (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .sdo_o     (sdo_o)
    );

    dds_reg_bank #(
        .ADDR0_RST (ADDR0_RST)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .upd_i     (upd_pulse),
        .active_o  (active_o)
    );

endmodule

// File: rtl/dds_serial_regs_chk.sv
module dds_serial_regs_chk
    import dds_regs_pkg::*;
(
    input logic          clk_i,
    input logic          rst_ni,
    input logic          csn_s,
    input logic          upd_pulse,
    input logic          sclk_rise,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          sdo_o,
    input bank_t         active_o
);

    function automatic logic high_bits_set(input bank_t b);
        logic any;
        any = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            for (int j = 0; j < MAXW; j++) begin
                if (j >= 8 * int'(reg_bytes(AW'(i)))) begin
                    any = any | b[i][j];
                end
            end
        end
        return any;
    endfunction

    AST_ACTIVE_ONLY_ON_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_pulse |=> $stable(active_o)); // R4

    AST_NO_WRITE_AFTER_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csn_s |=> !wr_en); // R6

    AST_SDO_QUIET_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csn_s |=> !sdo_o); // R8

    AST_WRITE_ADDR_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |-> (wr_addr < AW'(NREG))); // R7

    AST_WRITE_ON_SCLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |-> $past(sclk_rise)); // R5

    AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |=> !wr_en); // R3

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !high_bits_set(active_o)); // R9

endmodule

bind dds_serial_regs dds_serial_regs_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_s     (csn_s),
    .upd_pulse (upd_pulse),
    .sclk_rise (sclk_rise),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .sdo_o     (sdo_o),
    .active_o  (active_o)
);

// File: tb/sim_dds_serial_regs.sv
`timescale 1ns/1ps
module sim_dds_serial_regs;

    localparam int HB = 6;
    localparam logic [39:0] DEF0 = 40'h00_0000_0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, ioupd = 1'b0;
    logic sdo;
    logic [10:0][39:0] act;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [39:0] exp_hold [11];
    logic [39:0] exp_act  [11];

    always #4 clk = ~clk;

    dds_serial_regs u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .csn_i    (csn),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .ioupd_i  (ioupd),
        .sdo_o    (sdo),
        .active_o (act)
    );

    function automatic int nbytes(int a);
        case (a)
            0, 4, 6:      return 4;
            1:            return 3;
            2, 5:         return 2;
            3:            return 1;
            7, 8, 9, 10:  return 5;
            default:      return 0;
        endcase
    endfunction

    function automatic logic [39:0] pat(int a, int s);
        logic [39:0] v;
        v = '0;
        for (int k = 0; k < nbytes(a); k++) begin
            v[k*8 +: 8] = 8'((a * 37 + s * 59 + k * 101 + 7) & 255);
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [39:0] got, logic [39:0] want);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    task automatic chk_all(string tag);
        @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            chk(tag, act[i], exp_act[i]);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bit_out(logic b);
        sdi = b;
        wait_clk(HB);
        sclk = 1'b1;
        wait_clk(HB);
        sclk = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            bit_out(v[i]);
        end
    endtask

    task automatic cs_low();
        csn = 1'b0;
        wait_clk(HB);
    endtask

    task automatic cs_high();
        wait_clk(HB);
        csn = 1'b1;
        wait_clk(2 * HB);
    endtask

    task automatic pulse_upd();
        ioupd = 1'b1;
        wait_clk(HB);
        ioupd = 1'b0;
        wait_clk(2 * HB);
        for (int i = 0; i < 11; i++) begin
            exp_act[i] = exp_hold[i];
        end
    endtask

    task automatic write_reg(logic [7:0] inst, int a, logic [39:0] v);
        send_byte(inst);
        for (int k = nbytes(a) - 1; k >= 0; k--) begin
            send_byte(v[k*8 +: 8]);
        end
        exp_hold[a] = v;
    endtask

    task automatic read_reg(int a, output logic [39:0] v);
        v = '0;
        send_byte(8'h80 | 8'(a));
        for (int i = 0; i < nbytes(a) * 8; i++) begin
            @(negedge clk);
            v = {v[38:0], sdo};
            bit_out(1'b0);
        end
    endtask

    initial begin
        wait_clk(180000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] rv;
        for (int i = 0; i < 11; i++) begin
            exp_hold[i] = '0;
            exp_act[i]  = '0;
        end
        exp_act[0] = DEF0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        chk_all("R1 reset active bank");
        chk("R1 reset sdo", {39'b0, sdo}, 40'h0);

        // R8: read default of address 0 from the active bank
        cs_low();
        read_reg(0, rv);
        chk("R8 read reset default", rv, DEF0);
        cs_high();

        // R10: update with no write clears the default
        pulse_upd();
        chk_all("R10 update after reset");

        // R3 R5 R4 R9: burst writes of every register, then update, then burst reads
        for (int s = 1; s <= 3; s++) begin
            cs_low();
            for (int a = 0; a < 11; a++) begin
                write_reg(8'(a), a, pat(a, s));
            end
            cs_high();
            chk_all("R4 active unchanged before update");
            pulse_upd();
            chk_all("R3 R5 R9 burst write after update");
            cs_low();
            for (int a = 0; a < 11; a++) begin
                read_reg(a, rv);
                chk("R8 R5 burst readback", rv, exp_act[a]);
            end
            cs_high();
            chk("R8 sdo idle after read", {39'b0, sdo}, 40'h0);
        end

        // R3: one register per chip-select period
        for (int a = 0; a < 11; a++) begin
            cs_low();
            write_reg(8'(a), a, pat(a, 4));
            cs_high();
        end
        pulse_upd();
        chk_all("R3 separate periods");

        // R8 R4: read returns the active copy, not the pending holding value
        cs_low();
        write_reg(8'h04, 4, pat(4, 9));
        cs_high();
        cs_low();
        read_reg(4, rv);
        cs_high();
        chk("R8 read sees active not holding", rv, exp_act[4]);
        pulse_upd();
        chk_all("R4 pending value after update");

        // R6: abort mid-register, then a fresh instruction works
        cs_low();
        send_byte(8'h01);
        send_byte(8'hA5);
        send_byte(8'h5A);
        bit_out(1'b1);
        bit_out(1'b0);
        bit_out(1'b1);
        cs_high();
        cs_low();
        write_reg(8'h05, 5, pat(5, 11));
        cs_high();
        pulse_upd();
        chk_all("R6 abort keeps register, next instruction aligned");

        // R7: unmapped addresses swallow the rest of the period
        foreach (rv[i]) ;
        for (int u = 0; u < 2; u++) begin
            logic [7:0] bad;
            bad = (u == 0) ? 8'h0B : 8'h1F;
            cs_low();
            send_byte(bad);
            send_byte(8'h04);
            send_byte(8'hDE);
            send_byte(8'hAD);
            send_byte(8'hBE);
            send_byte(8'hEF);
            cs_high();
            pulse_upd();
            chk_all("R7 unmapped address ignored");
        end

        // R2: bits 6..5 of the instruction are ignored
        cs_low();
        write_reg(8'h66, 6, pat(6, 13));
        cs_high();
        pulse_upd();
        chk_all("R2 instruction bits 6..5 ignored");
        cs_low();
        send_byte(8'hE6);
        rv = '0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            rv = {rv[38:0], sdo};
            bit_out(1'b0);
        end
        cs_high();
        chk("R2 read with bits 6..5 set", rv, exp_act[6]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule